// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block sits between a small processor core and its data register file. Each cycle the core presents a 7-bit file offset, along with a write strobe and write data. The block works out which physical location that offset reaches and then completes the access. The data space has two banks of 128 locations. For a direct access, the bank comes from one bit of a status register held inside the block. An access to offset 00h is indirect: the full 8-bit value of an internal file select register is used as the address, and its top bit picks the bank.

The low 32 offsets of each bank hold special function registers. Above them is general purpose RAM. A fixed set of special function offsets reaches the same bank 0 register from either bank. The top sixteen offsets of bank 1 fold onto bank 0 as shared RAM. The rest of the bank 1 RAM window is not implemented.

The block contains the bank 0 RAM, the status register and the file select register. Every other special function register lives outside the block. For those, the block only raises a select strobe with a resolved bank and index, and passes the external read data back to the core.

Top module: `data_bank_mapper`

## Requirements
- R1: After reset, the status register and the file select register both read 00h on `status_q_o` and `fsr_q_o`.
- R2: For a direct access, the full address is {status bit 5, offset}. In bank 0, offsets 20h–7Fh are general purpose RAM that reads back the last value written.
- R3: In bank 1, offsets 20h–6Fh read 00h, and writes to them change no RAM cell.
- R4: Offsets 70h–7Fh reach the same RAM cell whether the bank is 0 or 1.
- R5: Offsets 00h, 02h, 03h, 04h, 0Ah and 0Bh resolve to bank 0 in either bank, so `ext_bank` is 0 for 02h, 0Ah and 0Bh.
- R6: An access at offset 00h uses `fsr_q_o` as the full address. Bit 7 selects the bank and bits 6:0 give the offset. All the mapping rules still apply to that address.
- R7: An indirect access whose address bits 6:0 are 00h reads 00h, ignores its write and raises no external select.
- R8: Any other offset below 20h raises `ext_sel` with `ext_idx` = offset and `ext_bank` = the resolved bank. `ext_we` is high only when the access is a write, and `acc_rdata` equals `ext_rdata`.
- R9: Writes take effect at the clock edge. A read of a location in the same cycle that writes it returns the old value.
- R10: Offset 03h is the status register and offset 04h is the file select register. Both are full 8-bit read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | An access is presented this cycle |
| acc_we | input | 1 | The access is a write |
| acc_offset | input | 7 | File offset within the bank |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data from the mapped location (00h when idle) |
| ext_sel | output | 1 | Strobe for an external special function register |
| ext_we | output | 1 | Write strobe for that external register |
| ext_bank | output | 1 | Resolved bank of the external register |
| ext_idx | output | 5 | Offset of the external register |
| ext_rdata | input | 8 | Read data returned by the external register |
| status_q_o | output | 8 | Current status register (bit 5 = bank select) |
| fsr_q_o | output | 8 | Current file select register |

## Verification
The bench first writes the whole bank 0 RAM. It then switches banks by writing the status register and probes offset 30h from both banks. If bank 1 RAM were wrongly implemented, it would return data there or overwrite the bank 0 cell. If the common window failed to fold, a value written at 75h in bank 1 would not appear at 75h in bank 0.

For mirrored and non-mirrored external offsets, the bench checks `ext_bank`. A design that applies the bank bit to 0Ah would strobe bank 1.

Several indirect pointers are tried: 80h, 00h, 83h, B5h and F5h. A design that recursed through 00h, or ignored bit 7 of the file select register, would return stale data or raise a strobe.

A long random run, checked against a bench-side model, also covers same-cycle read-before-write.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_STATUS = 3'd1,
    TGT_FSR    = 3'd2,
    TGT_EXT    = 3'd3,
    TGT_RAM    = 3'd4
  } dbm_tgt_e;
endpackage

// File: rtl/dbm_addr_decode.sv
module dbm_addr_decode
  import dbm_pkg::*;
#(
  parameter int OFS_W       = 7,
  parameter int SFR_SPAN    = 32,
  parameter int COMMON_BASE = 'h70,
  parameter int IND_OFS     = 0,
  parameter int STATUS_OFS  = 3,
  parameter int FSR_OFS     = 4,
  parameter logic [SFR_SPAN-1:0] MIRROR_MASK = 32'h0000_0C1D,
  parameter int IDX_W       = $clog2(SFR_SPAN),
  parameter int RAM_AW      = $clog2((1 << OFS_W) - SFR_SPAN)
) (
  input  logic [OFS_W-1:0]  offset,
  input  logic              bank_bit,
  input  logic [OFS_W:0]    fsr,
  output dbm_tgt_e          tgt,
  output logic [RAM_AW-1:0] ram_idx,
  output logic              ext_bank,
  output logic [IDX_W-1:0]  ext_idx
);
  localparam logic [OFS_W-1:0] SFR_END  = OFS_W'(SFR_SPAN);
  localparam logic [OFS_W-1:0] CMN_LO   = OFS_W'(COMMON_BASE);
  localparam logic [OFS_W-1:0] IND_A    = OFS_W'(IND_OFS);
  localparam logic [OFS_W-1:0] STATUS_A = OFS_W'(STATUS_OFS);
  localparam logic [OFS_W-1:0] FSR_A    = OFS_W'(FSR_OFS);

  logic [OFS_W:0]   full_addr;
  logic [OFS_W-1:0] eff_ofs;
  logic             is_sfr;
  logic             mirrored;
  logic             phys_bank;
  logic [OFS_W-1:0] ram_ofs;

  always_comb begin
    full_addr = (offset == IND_A) ? fsr : {bank_bit, offset};
    eff_ofs   = full_addr[OFS_W-1:0];
    is_sfr    = eff_ofs < SFR_END;
    mirrored  = is_sfr && MIRROR_MASK[eff_ofs[IDX_W-1:0]];
    phys_bank = full_addr[OFS_W] & ~mirrored;
    ram_ofs   = eff_ofs - SFR_END;
    ram_idx   = ram_ofs[RAM_AW-1:0];
    ext_bank  = phys_bank;
    ext_idx   = eff_ofs[IDX_W-1:0];
    if (eff_ofs == IND_A)                   tgt = TGT_NONE;
    else if (eff_ofs == STATUS_A)           tgt = TGT_STATUS;
    else if (eff_ofs == FSR_A)              tgt = TGT_FSR;
    else if (is_sfr)                        tgt = TGT_EXT;
    else if (phys_bank && eff_ofs < CMN_LO) tgt = TGT_NONE;
    else                                    tgt = TGT_RAM;
  end
endmodule

// File: rtl/dbm_gpr_ram.sv
module dbm_gpr_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 96,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && addr <= LAST) mem[addr] <= wdata;
  end

  always_comb rdata = (addr <= LAST) ? mem[addr] : '0;
endmodule

// File: rtl/dbm_core_regs.sv
module dbm_core_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              status_we,
  input  logic              fsr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] fsr_q
);
  logic [DATA_W-1:0] status_d;
  logic [DATA_W-1:0] fsr_d;

  always_comb begin
    status_d = status_we ? wdata : status_q;
    fsr_d    = fsr_we    ? wdata : fsr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      fsr_q    <= '0;
    end else begin
      status_q <= status_d;
      fsr_q    <= fsr_d;
    end
  end
endmodule

// File: rtl/data_bank_mapper.sv
module data_bank_mapper
  import dbm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OFS_W       = 7,
  parameter int SFR_SPAN    = 32,
  parameter int COMMON_BASE = 'h70,
  parameter int BANK_BIT    = 5,
  parameter logic [SFR_SPAN-1:0] MIRROR_MASK = 32'h0000_0C1D,
  localparam int IDX_W      = $clog2(SFR_SPAN),
  localparam int RAM_DEPTH  = (1 << OFS_W) - SFR_SPAN,
  localparam int RAM_AW     = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [OFS_W-1:0]  acc_offset,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              ext_sel,
  output logic              ext_we,
  output logic              ext_bank,
  output logic [IDX_W-1:0]  ext_idx,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic [DATA_W-1:0] status_q_o,
  output logic [DATA_W-1:0] fsr_q_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              wr_go;
  dbm_tgt_e          tgt;
  logic [RAM_AW-1:0] ram_idx;
  logic [DATA_W-1:0] ram_rdata;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] fsr_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dbm_addr_decode #(
    .OFS_W(OFS_W), .SFR_SPAN(SFR_SPAN), .COMMON_BASE(COMMON_BASE),
    .MIRROR_MASK(MIRROR_MASK)
  ) u_decode (
    .offset   (acc_offset),
    .bank_bit (status_q[BANK_BIT]),
    .fsr      (fsr_q[OFS_W:0]),
    .tgt      (tgt),
    .ram_idx  (ram_idx),
    .ext_bank (ext_bank),
    .ext_idx  (ext_idx)
  );

  assign wr_go = acc_en & acc_we;

  dbm_gpr_ram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_go && tgt == TGT_RAM),
    .addr  (ram_idx),
    .wdata (acc_wdata),
    .rdata (ram_rdata)
  );

  dbm_core_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .status_we (wr_go && tgt == TGT_STATUS),
    .fsr_we    (wr_go && tgt == TGT_FSR),
    .wdata     (acc_wdata),
    .status_q  (status_q),
    .fsr_q     (fsr_q)
  );

  always_comb begin
    ext_sel = acc_en && tgt == TGT_EXT;
    ext_we  = ext_sel && acc_we;
    if (!acc_en) acc_rdata = '0;
    else begin
      unique case (tgt)
        TGT_STATUS: acc_rdata = status_q;
        TGT_FSR:    acc_rdata = fsr_q;
        TGT_EXT:    acc_rdata = ext_rdata;
        TGT_RAM:    acc_rdata = ram_rdata;
        default:    acc_rdata = '0;
      endcase
    end
  end

  assign status_q_o = status_q;
  assign fsr_q_o    = fsr_q;
endmodule

// File: rtl/dbm_checker.sv
module dbm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_en,
  input logic       acc_we,
  input logic [6:0] acc_offset,
  input logic [7:0] acc_wdata,
  input logic [7:0] acc_rdata,
  input logic       ext_sel,
  input logic       ext_we,
  input logic       ext_bank,
  input logic [4:0] ext_idx,
  input logic [7:0] status_q_o,
  input logic [7:0] fsr_q_o
);
  AST_MIRROR_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && (ext_idx == 5'h02 || ext_idx == 5'h0A || ext_idx == 5'h0B)) |-> !ext_bank); // R5
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && status_q_o[5] && acc_offset >= 7'h20 && acc_offset < 7'h70) |-> acc_rdata == 8'h00); // R3
  AST_NULL_INDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_offset == 7'h00 && fsr_q_o[6:0] == 7'h00) |-> (acc_rdata == 8'h00 && !ext_sel)); // R7
  AST_FSR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_offset == 7'h04) |=> fsr_q_o == $past(acc_wdata)); // R10
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_we && (acc_offset == 7'h03 || acc_offset == 7'h00)) |=> $stable(status_q_o)); // R10
  AST_EXT_WE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> (ext_sel && acc_we)); // R8
  AST_RAM_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_offset >= 7'h20) |-> !ext_sel); // R2
endmodule

bind data_bank_mapper dbm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .acc_en     (acc_en),
  .acc_we     (acc_we),
  .acc_offset (acc_offset),
  .acc_wdata  (acc_wdata),
  .acc_rdata  (acc_rdata),
  .ext_sel    (ext_sel),
  .ext_we     (ext_we),
  .ext_bank   (ext_bank),
  .ext_idx    (ext_idx),
  .status_q_o (status_q_o),
  .fsr_q_o    (fsr_q_o)
);

// File: tb/data_bank_mapper_tb.sv
`timescale 1ns/1ps
module data_bank_mapper_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_en, acc_we;
  logic [6:0] acc_offset;
  logic [7:0] acc_wdata, acc_rdata, ext_rdata, status_q_o, fsr_q_o;
  logic       ext_sel, ext_we, ext_bank;
  logic [4:0] ext_idx;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_ram [256];
  logic [7:0] m_status, m_fsr;
  logic [7:0] last_rd;

  always #4 clk = ~clk;

  data_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_offset(acc_offset), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .ext_sel(ext_sel), .ext_we(ext_we), .ext_bank(ext_bank), .ext_idx(ext_idx),
    .ext_rdata(ext_rdata), .status_q_o(status_q_o), .fsr_q_o(fsr_q_o)
  );

  // canonical physical address: mirrored SFRs and common RAM fold to bank 0
  function automatic logic [7:0] canon(input logic [7:0] full);
    logic [6:0] o = full[6:0];
    logic       b = full[7];
    if (o inside {7'h00, 7'h02, 7'h03, 7'h04, 7'h0A, 7'h0B}) b = 1'b0;
    if (o >= 7'h70) b = 1'b0;
    return {b, o};
  endfunction

  // 0 none, 1 status, 2 fsr, 3 external, 4 ram
  function automatic int kind_of(input logic [7:0] c);
    if (c[6:0] == 7'h00) return 0;
    if (c[6:0] == 7'h03) return 1;
    if (c[6:0] == 7'h04) return 2;
    if (c[6:0] < 7'h20)  return 3;
    if (c[7])            return 0;
    return 4;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [6:0] off, input logic we, input logic [7:0] wd, input bit chk);
    logic [7:0] full, c, ev, exp_rd;
    int k;
    string tag;
    full = (off == 7'h00) ? m_fsr : {m_status[5], off};
    c = canon(full);
    k = kind_of(c);
    ev = 8'($urandom);
    @(negedge clk);
    acc_en = 1'b1; acc_we = we; acc_offset = off; acc_wdata = wd; ext_rdata = ev;
    #2;
    case (k)
      1: exp_rd = m_status;
      2: exp_rd = m_fsr;
      3: exp_rd = ev;
      4: exp_rd = m_ram[c];
      default: exp_rd = 8'h00;
    endcase
    last_rd = acc_rdata;
    if (chk) begin
      tag = (k == 4) ? "R2/R4/R9 ram" : (k == 3) ? "R8 ext" : (k == 0) ? "R3/R7 none" : "R10 core";
      if (off == 7'h00) tag = {"R6 ", tag};
      check(acc_rdata === exp_rd, tag, acc_rdata, exp_rd);
      check(ext_sel === (k == 3) && ext_we === (k == 3 && we), "R8 strobes",
            {ext_sel, ext_we}, {k == 3, k == 3 && we});
      if (k == 3)
        check(ext_bank === c[7] && ext_idx === c[4:0], "R5/R8 ext bank/idx",
              {ext_bank, ext_idx}, {c[7], c[4:0]});
    end
    @(posedge clk); #1;
    if (we) begin
      if (k == 1) m_status = wd;
      if (k == 2) m_fsr = wd;
      if (k == 4) m_ram[c] = wd;
    end
    acc_en = 1'b0; acc_we = 1'b0;
    if (chk && k inside {1, 2})
      check(status_q_o === m_status && fsr_q_o === m_fsr, "R10 regs",
            {status_q_o, fsr_q_o}, {m_status, m_fsr});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_status = 8'h00; m_fsr = 8'h00;
    acc_en = 0; acc_we = 0; acc_offset = 0; acc_wdata = 0; ext_rdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(status_q_o === 8'h00 && fsr_q_o === 8'h00, "R1 reset", {status_q_o, fsr_q_o}, 16'h0);

    for (int i = 32; i < 128; i++) access(7'(i), 1'b1, 8'(i * 7 + 3), 1'b0);

    // R2 / R9: write then same-cycle read of old value
    access(7'h30, 1'b1, 8'hA5, 1'b1);
    access(7'h30, 1'b1, 8'h3C, 1'b1);
    check(last_rd === 8'hA5, "R9 old value on write", last_rd, 8'hA5);
    access(7'h30, 1'b0, 8'h00, 1'b1);
    check(last_rd === 8'h3C, "R2 bank0 readback", last_rd, 8'h3C);

    // R3: bank 1 unimplemented window
    access(7'h03, 1'b1, 8'h20, 1'b1);
    access(7'h30, 1'b1, 8'h77, 1'b1);
    access(7'h30, 1'b0, 8'h00, 1'b1);
    check(last_rd === 8'h00, "R3 bank1 reads zero", last_rd, 8'h00);
    // R4: common window from bank 1
    access(7'h75, 1'b1, 8'h9E, 1'b1);
    // R5 / R8: mirrored vs plain SFR from bank 1
    access(7'h0A, 1'b1, 8'h11, 1'b1);
    access(7'h05, 1'b0, 8'h00, 1'b1);
    access(7'h03, 1'b1, 8'h00, 1'b1);
    access(7'h30, 1'b0, 8'h00, 1'b1);
    check(last_rd === 8'h3C, "R3 bank1 write left bank0 cell", last_rd, 8'h3C);
    access(7'h75, 1'b0, 8'h00, 1'b1);
    check(last_rd === 8'h9E, "R4 common cell shared", last_rd, 8'h9E);

    // R6 / R7: indirect access
    access(7'h04, 1'b1, 8'h35, 1'b1);
    access(7'h00, 1'b1, 8'h5A, 1'b1);
    access(7'h35, 1'b0, 8'h00, 1'b1);
    check(last_rd === 8'h5A, "R6 indirect write landed", last_rd, 8'h5A);
    access(7'h04, 1'b1, 8'hB5, 1'b1);
    access(7'h00, 1'b0, 8'h00, 1'b1);
    check(last_rd === 8'h00, "R6 indirect bank1 unimpl", last_rd, 8'h00);
    access(7'h04, 1'b1, 8'hF5, 1'b1);
    access(7'h00, 1'b0, 8'h00, 1'b1);
    check(last_rd === 8'h9E, "R6 indirect common", last_rd, 8'h9E);
    access(7'h04, 1'b1, 8'h80, 1'b1);
    access(7'h00, 1'b1, 8'hEE, 1'b1);
    check(last_rd === 8'h00 && fsr_q_o === 8'h80, "R7 null indirect", {last_rd, fsr_q_o}, 16'h0080);
    access(7'h04, 1'b1, 8'h00, 1'b1);
    access(7'h00, 1'b1, 8'hEE, 1'b1);
    access(7'h04, 1'b1, 8'h83, 1'b1);
    access(7'h00, 1'b0, 8'h00, 1'b1);
    check(last_rd === 8'h00, "R10 status via indirect 83h", last_rd, 8'h00);

    // random mix against the model
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] off = 7'($urandom_range(0, 127));
      if ($urandom_range(0, 9) == 0) off = 7'($urandom_range(0, 4));
      access(off, 1'($urandom), 8'($urandom), 1'b1);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule